// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block paces the measurement phases of a front end with up to four sensing channels. For each channel it opens a settling window that lets the sensor oscillation stabilise. A conversion window follows, during which an external counter measures the channel, and then a short gap while the input switch moves on. The block tells the counter which channel is live and which window is open. When a conversion window closes normally, it raises a sticky per-channel ready flag that a host can use as an interrupt source.

In single-channel mode the block converts one chosen channel over and over. In scan mode it walks an ascending round-robin list of two, three or four channels, chosen by a 2-bit code. It pulses a pass marker each time the last channel of the list finishes, so a complete set of results is then available. Settle and conversion lengths come from per-channel 16-bit counts, each scaled by a power-of-two factor in reference clock cycles. The gap is a fixed parameter. All configuration arrives as plain parallel inputs. Any change to them restarts the sequence.

There is no data stream at the block's edge. Every pin is plain control or status, so no valid/ready handshake or back-pressure applies. One clock cycle equals one reference clock period.

Top module: `conv_sequencer`

## Requirements
- R1: While rst_n is low, chan_idx is 0 and settle_en, conv_en, ready and pass_done are all 0.
- R2: With scan_en = 0, every settle and conversion window belongs to the channel numbered by sel_chan (0 to 3). The windows repeat on that channel without end.
- R3: With scan_en = 1, channels are visited in ascending order from channel 0 and wrap back to 0. seq_code 00 lists channels 0 and 1; 01 lists channels 0 to 2; 10 lists channels 0 to 3.
- R4: seq_code 11 behaves exactly like 10 and scans all four channels.
- R5: Each channel's dwell is a settle window (settle_en = 1), then a conversion window (conv_en = 1), then a gap of SWITCH_CYCLES cycles with both low. settle_en and conv_en are never high together, and chan_idx holds during the whole dwell.
- R6: The settle window of channel i lasts settle_cnt[16i+15:16i] × 2^SCALE_LOG2 cycles (× 16 by default).
- R7: The conversion window of channel i lasts conv_cnt[16i+15:16i] × 2^SCALE_LOG2 cycles.
- R8: A count of zero in either field acts as a count of one.
- R9: ready[i] becomes 1 in the first gap cycle after a completed conversion of channel i. It stays 1 until a cycle with ready_clr[i] = 1. When set and clear fall in the same cycle, the set wins.
- R10: pass_done is high for exactly one cycle: the first gap cycle after the last channel of the list. In single-channel mode that is after every conversion.
- R11: When any configuration input changes, the cycle after the change shows a settle window on the start channel: channel 0 in scan mode, sel_chan in single mode. That settle window has its full length. An interrupted conversion sets no ready flag.
- R12: The first clock edge after reset is released starts a settle window on the start channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle is one reference period |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 0 = single-channel mode, 1 = round-robin scan |
| sel_chan | input | 2 | Channel converted in single-channel mode |
| seq_code | input | 2 | Scan list select (00: 0-1, 01: 0-2, 10/11: 0-3) |
| settle_cnt | input | 64 | Settle count per channel, channel i at bits [16i+15:16i] |
| conv_cnt | input | 64 | Conversion count per channel, channel i at bits [16i+15:16i] |
| ready_clr | input | 4 | One-cycle clear of the matching ready bits |
| chan_idx | output | 2 | Channel currently dwelt on |
| settle_en | output | 1 | High during the settle window |
| conv_en | output | 1 | High during the conversion window |
| ready | output | 4 | Sticky per-channel result-ready flags |
| pass_done | output | 1 | One-cycle marker that a full list has completed |

## Verification
The bench builds the block with four channels and the default scale of 16 cycles per count. It sets SWITCH_CYCLES to 3 instead of the default 4, so a gap length taken from a hardwired constant rather than the parameter would be caught. Counts of 0 to 4 keep every window between 16 and 64 cycles. That short length lets the bench follow every cycle of each window over two full passes of every list, and it brings the zero-count case, set/clear collisions and restarts in the middle of a conversion into reach.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CONV   = 2'd2,
    PH_GAP    = 2'd3
  } phase_e;
endpackage

// File: rtl/conv_seq_cfg_watch.sv
`timescale 1ns/1ps
// Restart request: first edge after reset, or any change of the configuration word.
module conv_seq_cfg_watch #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  output logic             restart
);
  logic [CFG_W-1:0] snap_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      snap_q  <= cfg;
      armed_q <= 1'b1;
    end
  end

  assign restart = !armed_q || (cfg != snap_q);
endmodule

// File: rtl/conv_seq_chan_pick.sv
`timescale 1ns/1ps
// Channel selection: start channel, successor and end-of-list flag.
module conv_seq_chan_pick #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            scan_en,
  input  logic [CH_W-1:0] sel_chan,
  input  logic [1:0]      seq_code,
  input  logic [CH_W-1:0] cur_chan,
  output logic [CH_W-1:0] start_chan,
  output logic [CH_W-1:0] next_chan,
  output logic            is_last
);
  localparam int LEN_W = CH_W + 3;

  logic [LEN_W-1:0] raw_len;
  logic [LEN_W-1:0] list_len;

  always_comb begin
    case (seq_code)
      2'b00:   raw_len = LEN_W'(2);
      2'b01:   raw_len = LEN_W'(3);
      default: raw_len = LEN_W'(4);
    endcase
    list_len = (raw_len > LEN_W'(NUM_CH)) ? LEN_W'(NUM_CH) : raw_len;
  end

  always_comb begin
    if (scan_en) begin
      start_chan = '0;
      is_last    = (LEN_W'(cur_chan) == (list_len - LEN_W'(1)));
      next_chan  = is_last ? '0 : (cur_chan + CH_W'(1));
    end else begin
      start_chan = sel_chan;
      is_last    = 1'b1;
      next_chan  = sel_chan;
    end
  end
endmodule

// File: rtl/conv_seq_phase_len.sv
`timescale 1ns/1ps
// Terminal count of the current phase, from the per-channel count fields.
module conv_seq_phase_len
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int CH_W          = 2,
  parameter int CNT_W         = 16,
  parameter int SCALE_LOG2    = 4,
  parameter int SWITCH_CYCLES = 4,
  parameter int TW            = CNT_W + SCALE_LOG2
) (
  input  logic [NUM_CH*CNT_W-1:0] settle_cnt,
  input  logic [NUM_CH*CNT_W-1:0] conv_cnt,
  input  logic [CH_W-1:0]         chan,
  input  phase_e                  phase,
  output logic [TW-1:0]           term
);
  logic [TW-1:0] settle_m1 [NUM_CH];
  logic [TW-1:0] conv_m1   [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_len
    logic [CNT_W-1:0] s_raw, c_raw, s_eff, c_eff;
    assign s_raw = settle_cnt[i*CNT_W +: CNT_W];
    assign c_raw = conv_cnt[i*CNT_W +: CNT_W];
    assign s_eff = (s_raw == '0) ? CNT_W'(1) : s_raw;
    assign c_eff = (c_raw == '0) ? CNT_W'(1) : c_raw;
    assign settle_m1[i] = (TW'(s_eff) << SCALE_LOG2) - TW'(1);
    assign conv_m1[i]   = (TW'(c_eff) << SCALE_LOG2) - TW'(1);
  end

  always_comb begin
    case (phase)
      PH_SETTLE: term = settle_m1[chan];
      PH_CONV:   term = conv_m1[chan];
      PH_GAP:    term = TW'(SWITCH_CYCLES - 1);
      default:   term = '0;
    endcase
  end
endmodule

// File: rtl/conv_seq_ready_bank.sv
`timescale 1ns/1ps
// Sticky per-channel ready flags; a set beats a clear in the same cycle.
module conv_seq_ready_bank #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CH_W-1:0]   set_chan,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] ready
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ready[i] <= 1'b0;
      else if (set_en && (set_chan == CH_W'(i)))    ready[i] <= 1'b1;
      else if (clr[i])                              ready[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int CNT_W         = 16,
  parameter int SCALE_LOG2    = 4,
  parameter int SWITCH_CYCLES = 4,
  parameter int CH_W          = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_en,
  input  logic [CH_W-1:0]         sel_chan,
  input  logic [1:0]              seq_code,
  input  logic [NUM_CH*CNT_W-1:0] settle_cnt,
  input  logic [NUM_CH*CNT_W-1:0] conv_cnt,
  input  logic [NUM_CH-1:0]       ready_clr,
  output logic [CH_W-1:0]         chan_idx,
  output logic                    settle_en,
  output logic                    conv_en,
  output logic [NUM_CH-1:0]       ready,
  output logic                    pass_done
);
  localparam int TW    = CNT_W + SCALE_LOG2;
  localparam int CFG_W = 1 + CH_W + 2 + 2 * NUM_CH * CNT_W;

  phase_e          phase_q;
  logic [CH_W-1:0] chan_q;
  logic [TW-1:0]   cnt_q;
  logic            pass_q;

  logic            restart;
  logic [CH_W-1:0] start_chan, next_chan;
  logic            is_last;
  logic [TW-1:0]   term;
  logic            at_end;
  logic            conv_done;

  conv_seq_cfg_watch #(.CFG_W(CFG_W)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     ({scan_en, sel_chan, seq_code, settle_cnt, conv_cnt}),
    .restart (restart)
  );

  conv_seq_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .scan_en    (scan_en),
    .sel_chan   (sel_chan),
    .seq_code   (seq_code),
    .cur_chan   (chan_q),
    .start_chan (start_chan),
    .next_chan  (next_chan),
    .is_last    (is_last)
  );

  conv_seq_phase_len #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W),
    .SCALE_LOG2(SCALE_LOG2), .SWITCH_CYCLES(SWITCH_CYCLES), .TW(TW)
  ) u_len (
    .settle_cnt (settle_cnt),
    .conv_cnt   (conv_cnt),
    .chan       (chan_q),
    .phase      (phase_q),
    .term       (term)
  );

  assign at_end    = (cnt_q == term);
  assign conv_done = !restart && (phase_q == PH_CONV) && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      chan_q  <= '0;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
    end else if (restart) begin
      phase_q <= PH_SETTLE;
      chan_q  <= start_chan;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
    end else begin
      pass_q <= 1'b0;
      if (phase_q != PH_IDLE) begin
        if (at_end) begin
          cnt_q <= '0;
          case (phase_q)
            PH_SETTLE: phase_q <= PH_CONV;
            PH_CONV: begin
              phase_q <= PH_GAP;
              pass_q  <= is_last;
            end
            default: begin
              phase_q <= PH_SETTLE;
              chan_q  <= next_chan;
            end
          endcase
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

  conv_seq_ready_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ready (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (conv_done),
    .set_chan (chan_q),
    .clr      (ready_clr),
    .ready    (ready)
  );

  assign chan_idx  = chan_q;
  assign settle_en = (phase_q == PH_SETTLE);
  assign conv_en   = (phase_q == PH_CONV);
  assign pass_done = pass_q;
endmodule

// File: rtl/conv_sequencer_chk.sv
`timescale 1ns/1ps
module conv_sequencer_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scan_en,
  input logic [CH_W-1:0]         sel_chan,
  input logic [1:0]              seq_code,
  input logic [NUM_CH*CNT_W-1:0] settle_cnt,
  input logic [NUM_CH*CNT_W-1:0] conv_cnt,
  input logic [NUM_CH-1:0]       ready_clr,
  input logic [CH_W-1:0]         chan_idx,
  input logic                    settle_en,
  input logic                    conv_en,
  input logic [NUM_CH-1:0]       ready,
  input logic                    pass_done
);
  localparam int CFG_W = 1 + CH_W + 2 + 2 * NUM_CH * CNT_W;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             seen_q;
  logic             same;
  logic [CH_W:0]    top_chan;

  assign cfg_now = {scan_en, sel_chan, seq_code, settle_cnt, conv_cnt};
  assign same    = seen_q && (cfg_now == cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_now;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    case (seq_code)
      2'b00:   top_chan = (CH_W+1)'(1);
      2'b01:   top_chan = (CH_W+1)'(2);
      default: top_chan = (CH_W+1)'(3);
    endcase
    if (top_chan > (CH_W+1)'(NUM_CH - 1)) top_chan = (CH_W+1)'(NUM_CH - 1);
  end

  p_single_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && $stable(scan_en) && $stable(sel_chan) && (settle_en || conv_en))
      |-> (chan_idx == sel_chan));

  p_scan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && $stable(scan_en) && $stable(seq_code) && (settle_en || conv_en))
      |-> ({1'b0, chan_idx} <= top_chan));

  p_window_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(settle_en && conv_en));

  p_settle_to_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(settle_en) && $past(same)) |-> conv_en);

  p_conv_to_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_en) && $past(same)) |-> (!settle_en && $stable(chan_idx)));

  p_ready_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_en) && $past(same)) |-> ready[$past(chan_idx)]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sticky
    p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready[i]) |-> $past(ready_clr[i]));
  end

  p_pass_in_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (!settle_en && !conv_en));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seen_q && !same)
      |-> (settle_en && (chan_idx == ($past(scan_en) ? CH_W'(0) : $past(sel_chan)))));
endmodule

bind conv_sequencer conv_sequencer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .sel_chan   (sel_chan),
  .seq_code   (seq_code),
  .settle_cnt (settle_cnt),
  .conv_cnt   (conv_cnt),
  .ready_clr  (ready_clr),
  .chan_idx   (chan_idx),
  .settle_en  (settle_en),
  .conv_en    (conv_en),
  .ready      (ready),
  .pass_done  (pass_done)
);

// File: tb/test_conv_sequencer.sv
`timescale 1ns/1ps
module test_conv_sequencer;
  localparam int SW = 3;

  typedef struct packed {
    logic             scan;
    logic [1:0]       sel;
    logic [1:0]       code;
    logic [3:0][15:0] sc;
    logic [3:0][15:0] cc;
    logic [2:0]       n;
  } vec_t;

  // sc/cc literals list channel 3 first, channel 0 last
  localparam vec_t VECS [6] = '{
    '{1'b0, 2'd1, 2'd0, {16'd1, 16'd1, 16'd2, 16'd1}, {16'd1, 16'd1, 16'd1, 16'd1}, 3'd1},
    '{1'b1, 2'd3, 2'd0, {16'd4, 16'd4, 16'd1, 16'd2}, {16'd4, 16'd4, 16'd2, 16'd1}, 3'd2},
    '{1'b1, 2'd0, 2'd1, {16'd1, 16'd1, 16'd1, 16'd1}, {16'd1, 16'd2, 16'd1, 16'd3}, 3'd3},
    '{1'b1, 2'd2, 2'd2, {16'd2, 16'd1, 16'd1, 16'd1}, {16'd1, 16'd1, 16'd1, 16'd1}, 3'd4},
    '{1'b1, 2'd1, 2'd3, {16'd1, 16'd1, 16'd1, 16'd1}, {16'd2, 16'd1, 16'd1, 16'd1}, 3'd4},
    '{1'b0, 2'd3, 2'd2, {16'd0, 16'd1, 16'd1, 16'd1}, {16'd0, 16'd1, 16'd1, 16'd1}, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic [1:0]  sel_chan = '0;
  logic [1:0]  seq_code = '0;
  logic [63:0] settle_cnt = '0;
  logic [63:0] conv_cnt = '0;
  logic [3:0]  ready_clr = '0;
  logic [1:0]  chan_idx;
  logic        settle_en, conv_en, pass_done;
  logic [3:0]  ready;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  conv_sequencer #(.SWITCH_CYCLES(SW)) i_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .sel_chan(sel_chan),
    .seq_code(seq_code), .settle_cnt(settle_cnt), .conv_cnt(conv_cnt),
    .ready_clr(ready_clr), .chan_idx(chan_idx), .settle_en(settle_en),
    .conv_en(conv_en), .ready(ready), .pass_done(pass_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned win(input logic [15:0] c);
    return ((c == 16'd0) ? 1 : int'(c)) * 16;
  endfunction

  // Walk one window cycle by cycle; word layout {chan, settle, conv, pass}
  task automatic seg(input logic [1:0] ch, input bit se, input bit ce, input int unsigned len,
                     input bit pd_first, input bit clr_first, input string req);
    int bad = 0;
    logic [4:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < int'(len); i++) begin
      logic [4:0] act, exp;
      act = {chan_idx, settle_en, conv_en, pass_done};
      exp = {ch, se, ce, (pd_first && i == 0)};
      if (act !== exp) begin
        if (bad == 0) begin first_act = act; first_exp = exp; end
        bad++;
      end
      ready_clr = (clr_first && i == 0) ? (4'b0001 << ch) : 4'b0000;
      @(negedge clk);
    end
    ready_clr = '0;
    check(bad == 0, req, "window {chan,settle,conv,pass}", 32'(first_act), 32'(first_exp));
  endtask

  task automatic apply(input vec_t v);
    scan_en = v.scan; sel_chan = v.sel; seq_code = v.code;
    settle_cnt = v.sc; conv_cnt = v.cc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    check({chan_idx, settle_en, conv_en, ready, pass_done} === 9'd0, "R1", "outputs in reset",
          32'({chan_idx, settle_en, conv_en, ready, pass_done}), 32'd0);
    rst_n = 1'b1;

    for (int vi = 0; vi < 6; vi++) begin
      vec_t  v;
      string rq;
      v = VECS[vi];
      rq = (vi == 4) ? "R4" : (vi == 5) ? "R8" : v.scan ? "R3" : "R2";
      apply(v);
      @(posedge clk);
      @(negedge clk);
      if (vi == 0)
        check(settle_en === 1'b1 && chan_idx === v.sel, "R12", "start after reset",
              32'({chan_idx, settle_en}), 32'({v.sel, 1'b1}));
      for (int pass = 0; pass < 2; pass++) begin
        for (int k = 0; k < int'(v.n); k++) begin
          logic [1:0] ch;
          ch = v.scan ? 2'(k) : v.sel;
          seg(ch, 1'b1, 1'b0, win(v.sc[ch]), 1'b0, 1'b1, {rq, "/R6 settle"});
          check(ready[ch] === 1'b0, "R9", "ready cleared", 32'(ready[ch]), 32'd0);
          seg(ch, 1'b0, 1'b1, win(v.cc[ch]), 1'b0, 1'b0, {rq, "/R7 conv"});
          check(ready[ch] === 1'b1, "R9", "ready set at gap", 32'(ready[ch]), 32'd1);
          seg(ch, 1'b0, 1'b0, SW, (k == int'(v.n) - 1), 1'b0, {rq, "/R5/R10 gap"});
        end
      end
    end

    // R9: set beats clear, clear works, flag is sticky
    scan_en = 1'b0; sel_chan = 2'd0; seq_code = 2'd0;
    settle_cnt = {16'd1, 16'd1, 16'd1, 16'd1}; conv_cnt = {16'd1, 16'd1, 16'd1, 16'd1};
    @(posedge clk); @(negedge clk);          // cycle 0
    repeat (31) @(negedge clk);              // cycle 31, last conversion cycle
    ready_clr = 4'b0001;
    @(negedge clk);                          // cycle 32, gap 0
    ready_clr = 4'b0000;
    check(ready[0] === 1'b1, "R9", "set wins over clear", 32'(ready[0]), 32'd1);
    ready_clr = 4'b0001;
    @(negedge clk);                          // cycle 33
    ready_clr = 4'b0000;
    check(ready[0] === 1'b0, "R9", "clear takes effect", 32'(ready[0]), 32'd0);
    repeat (34) @(negedge clk);              // cycle 67, gap 0 of next dwell
    check(ready[0] === 1'b1, "R9", "set again", 32'(ready[0]), 32'd1);
    repeat (20) @(negedge clk);              // cycle 87, next dwell
    check(ready[0] === 1'b1, "R9", "sticky without clear", 32'(ready[0]), 32'd1);

    // R11: change in mid conversion
    scan_en = 1'b1; seq_code = 2'd0;
    settle_cnt = {16'd1, 16'd1, 16'd1, 16'd1}; conv_cnt = {16'd1, 16'd1, 16'd1, 16'd4};
    @(posedge clk); @(negedge clk);          // cycle 0
    ready_clr = 4'b1111;
    @(negedge clk);
    ready_clr = 4'b0000;
    repeat (25) @(negedge clk);              // cycle 26, conversion of ch0
    check(conv_en === 1'b1 && chan_idx === 2'd0, "R11", "in conversion before change",
          32'({chan_idx, conv_en}), 32'({2'd0, 1'b1}));
    conv_cnt = {16'd2, 16'd1, 16'd1, 16'd4};
    @(negedge clk);
    seg(2'd0, 1'b1, 1'b0, 16, 1'b0, 1'b0, "R11 restart settle");
    check(ready[0] === 1'b0, "R11", "no ready after abort", 32'(ready[0]), 32'd0);
    scan_en = 1'b0; sel_chan = 2'd2;
    @(negedge clk);
    check(settle_en === 1'b1 && chan_idx === 2'd2, "R11", "restart on selected channel",
          32'({chan_idx, settle_en}), 32'({2'd2, 1'b1}));

    // R1: reset asserted mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check({chan_idx, settle_en, conv_en, ready, pass_done} === 9'd0, "R1", "outputs after reset",
          32'({chan_idx, settle_en, conv_en, ready, pass_done}), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule